// File: doc/BRIEF.md
# Free-Running Timer with Input Capture and Output Compare

This block is a 16-bit up-counter that never stops. It advances by one whenever a single-cycle count-enable pulse arrives from a tick source that is slower than the system clock. Between pulses the counter holds its value for any number of system clocks. When the counter reaches 0xFFFF, the next pulse wraps it to 0x0000.

Four capture channels record the counter value. When a channel's already-synchronized capture pulse occurs, the channel copies the counter into its own register and raises a sticky flag in the same edge. Two compare channels each hold a value that software writes through a small synchronous port. A compare channel raises its own sticky flag only in the system-clock cycle that carries the count-enable pulse while the counter equals the stored value, which is the last cycle of that count. A match therefore produces exactly one flag-set event per count period, however long the count lasts. Each flag has its own clear strobe.

Top module: `frt_capcmp`

## Requirements
- R1: The counter resets to 0x0000. It increases by exactly one on each cycle where `cnt_en` is 1, holds otherwise, and wraps from 0xFFFF to 0x0000.
- R2: A pulse on `cap_pulse[i]` loads capture register i with the counter value as it stood in that cycle, before any increment in the same cycle. The new value appears on `cap_val_o` one cycle later. Channel i occupies bits `[16*i+15:16*i]`.
- R3: The four capture channels act independently. A pulse on one channel leaves the other channels' registers and flags unchanged, and simultaneous pulses on several channels each load their own register.
- R4: `cap_flag_o[i]` goes to 1 in the same edge that loads capture register i and stays at 1 until `cap_clr[i]` is pulsed. If a capture pulse and a clear strobe arrive together, the flag stays set.
- R5: `cmp_flag_o[j]` is set only by a cycle where `cnt_en` is 1 and the counter equals compare register j. The counter equalling the compare value while `cnt_en` is 0 does not set the flag.
- R6: A match sets the compare flag only once per count. If the flag is cleared while the counter still holds the matching value and no enable pulse arrives, the flag stays 0.
- R7: Compare flags are sticky and are cleared by `cmp_clr[j]`. A match and a clear in the same cycle leave the flag set.
- R8: Compare registers reset to 0xFFFF. Register j (j = 0 or 1, chosen by `cmp_wr_sel`) loads `cmp_wr_data` when `cmp_wr_en` is 1. `cmp_rd_data` shows register `cmp_rd_sel` as it stood one clock edge earlier, so a write is readable two cycles after it is driven.
- R9: After reset, every capture register reads 0x0000 and every flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-enable pulse from the tick source |
| cap_pulse | input | 4 | Capture event per channel, one cycle wide |
| cap_clr | input | 4 | Clear strobe for each capture flag |
| cmp_wr_en | input | 1 | Compare register write strobe |
| cmp_wr_sel | input | 1 | Compare register selected for write |
| cmp_wr_data | input | 16 | Compare write data |
| cmp_rd_sel | input | 1 | Compare register selected for read |
| cmp_clr | input | 2 | Clear strobe for each compare flag |
| count_o | output | 16 | Current counter value |
| cap_val_o | output | 64 | Capture registers, channel i at bits 16*i upward |
| cap_flag_o | output | 4 | Capture flags |
| cmp_flag_o | output | 2 | Compare flags |
| cmp_rd_data | output | 16 | Registered compare read data |

## Verification
Every result of this block appears one edge after the stimulus that causes it. This applies to the counter step, the capture value and its flag, the compare flag, and the read data, which samples the compare register one edge after a write has landed. The driver applies inputs on the falling edge. For each input cycle it queues the expected outputs, tagged with the cycle number after the next rising edge. The monitor compares them shortly after that rising edge. Because of this, a result that comes a cycle early or late shows up as a mismatch instead of being absorbed. The interesting timings are capture coinciding with an increment, a compare value held for many system clocks, and a clear racing a set.

// File: rtl/frt_pkg.sv
package frt_pkg;

    // Default geometry of the timer
    localparam int DEF_CNT_W   = 16;
    localparam int DEF_NUM_CAP = 4;
    localparam int DEF_NUM_CMP = 2;

    // Sticky status bit: a set event wins over a clear strobe
    function automatic logic sticky_next(input logic cur, input logic set_ev, input logic clr_ev);
        logic r;
        r = cur;
        if (clr_ev) r = 1'b0;
        if (set_ev) r = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    output logic [W-1:0] count
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cnt_en) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/frt_capture_ch.sv
module frt_capture_ch
    import frt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_pulse,
    input  logic         cap_clr,
    input  logic [W-1:0] count,
    output logic [W-1:0] cap_val,
    output logic         cap_flag
);

    typedef struct packed {
        logic [W-1:0] val;
        logic         flag;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = sticky_next(st_q.flag, cap_pulse, cap_clr);
        if (cap_pulse) begin
            // counter register output is the pre-increment value
            st_d.val = count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_val  = st_q.val;
    assign cap_flag = st_q.flag;

endmodule

// File: rtl/frt_compare_ch.sv
module frt_compare_ch
    import frt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         cnt_en,
    input  logic [W-1:0] count,
    input  logic         cmp_clr,
    output logic [W-1:0] cmp_val,
    output logic         cmp_flag
);

    typedef struct packed {
        logic [W-1:0] val;
        logic         flag;
    } cmp_st_t;

    localparam cmp_st_t RST_ST = '{val: '1, flag: 1'b0};

    cmp_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        // match only in the last system cycle of the count
        hit       = cnt_en && (count == st_q.val);
        st_d      = st_q;
        st_d.flag = sticky_next(st_q.flag, hit, cmp_clr);
        if (wr_en) begin
            st_d.val = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_val  = st_q.val;
    assign cmp_flag = st_q.flag;

endmodule

// File: rtl/frt_capcmp.sv
module frt_capcmp
    import frt_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int NUM_CAP = DEF_NUM_CAP,
    parameter int NUM_CMP = DEF_NUM_CMP,
    localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cnt_en,
    input  logic [NUM_CAP-1:0]       cap_pulse,
    input  logic [NUM_CAP-1:0]       cap_clr,
    input  logic                     cmp_wr_en,
    input  logic [SEL_W-1:0]         cmp_wr_sel,
    input  logic [CNT_W-1:0]         cmp_wr_data,
    input  logic [SEL_W-1:0]         cmp_rd_sel,
    input  logic [NUM_CMP-1:0]       cmp_clr,
    output logic [CNT_W-1:0]         count_o,
    output logic [NUM_CAP*CNT_W-1:0] cap_val_o,
    output logic [NUM_CAP-1:0]       cap_flag_o,
    output logic [NUM_CMP-1:0]       cmp_flag_o,
    output logic [CNT_W-1:0]         cmp_rd_data
);

    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] cmp_vals [NUM_CMP];

    frt_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .count  (cnt_w)
    );

    for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap
        frt_capture_ch #(.W(CNT_W)) u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap_pulse (cap_pulse[i]),
            .cap_clr   (cap_clr[i]),
            .count     (cnt_w),
            .cap_val   (cap_val_o[i*CNT_W +: CNT_W]),
            .cap_flag  (cap_flag_o[i])
        );
    end

    for (genvar j = 0; j < NUM_CMP; j++) begin : g_cmp
        logic wr_hit;
        assign wr_hit = cmp_wr_en && (cmp_wr_sel == SEL_W'(j));
        frt_compare_ch #(.W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_hit),
            .wr_data  (cmp_wr_data),
            .cnt_en   (cnt_en),
            .count    (cnt_w),
            .cmp_clr  (cmp_clr[j]),
            .cmp_val  (cmp_vals[j]),
            .cmp_flag (cmp_flag_o[j])
        );
    end

    // registered read port
    typedef struct packed {
        logic [CNT_W-1:0] rd;
    } rd_st_t;

    localparam rd_st_t RD_RST = '{rd: '1};

    rd_st_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (int'(cmp_rd_sel) < NUM_CMP) begin
            rd_d.rd = cmp_vals[cmp_rd_sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= RD_RST;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign count_o     = cnt_w;
    assign cmp_rd_data = rd_q.rd;

endmodule

// File: rtl/frt_capcmp_chk.sv
module frt_capcmp_chk #(
    parameter int CNT_W   = 16,
    parameter int NUM_CAP = 4,
    parameter int NUM_CMP = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cnt_en,
    input logic [NUM_CAP-1:0]       cap_pulse,
    input logic [NUM_CAP-1:0]       cap_clr,
    input logic [NUM_CMP-1:0]       cmp_clr,
    input logic [CNT_W-1:0]         count_o,
    input logic [NUM_CAP*CNT_W-1:0] cap_val_o,
    input logic [NUM_CAP-1:0]       cap_flag_o,
    input logic [NUM_CMP-1:0]       cmp_flag_o
);

    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> count_o == $past(count_o));

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> count_o == CNT_W'($past(count_o) + CNT_W'(1)));

    for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap_chk
        assert_cap_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cap_pulse[i] |=> cap_flag_o[i] && (cap_val_o[i*CNT_W +: CNT_W] == $past(count_o)));

        assert_cap_val_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_pulse[i] |=> $stable(cap_val_o[i*CNT_W +: CNT_W]));

        assert_cap_flag_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!cap_pulse[i] && !cap_clr[i]) |=> $stable(cap_flag_o[i]));
    end

    for (genvar j = 0; j < NUM_CMP; j++) begin : g_cmp_chk
        assert_cmp_rise_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cmp_flag_o[j]) |-> $past(cnt_en));

        assert_cmp_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_clr[j] && !cnt_en) |=> !cmp_flag_o[j]);
    end

endmodule

bind frt_capcmp frt_capcmp_chk #(
    .CNT_W   (CNT_W),
    .NUM_CAP (NUM_CAP),
    .NUM_CMP (NUM_CMP)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .cap_pulse  (cap_pulse),
    .cap_clr    (cap_clr),
    .cmp_clr    (cmp_clr),
    .count_o    (count_o),
    .cap_val_o  (cap_val_o),
    .cap_flag_o (cap_flag_o),
    .cmp_flag_o (cmp_flag_o)
);

// File: tb/test_frt_capcmp.sv
module test_frt_capcmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [3:0]  cap_pulse = '0;
    logic [3:0]  cap_clr = '0;
    logic        cmp_wr_en = 1'b0;
    logic        cmp_wr_sel = 1'b0;
    logic [15:0] cmp_wr_data = '0;
    logic        cmp_rd_sel = 1'b0;
    logic [1:0]  cmp_clr = '0;
    logic [15:0] count_o;
    logic [63:0] cap_val_o;
    logic [3:0]  cap_flag_o;
    logic [1:0]  cmp_flag_o;
    logic [15:0] cmp_rd_data;

    always #4 clk = ~clk;   // 125 MHz

    frt_capcmp i_frt_capcmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_en      (cnt_en),
        .cap_pulse   (cap_pulse),
        .cap_clr     (cap_clr),
        .cmp_wr_en   (cmp_wr_en),
        .cmp_wr_sel  (cmp_wr_sel),
        .cmp_wr_data (cmp_wr_data),
        .cmp_rd_sel  (cmp_rd_sel),
        .cmp_clr     (cmp_clr),
        .count_o     (count_o),
        .cap_val_o   (cap_val_o),
        .cap_flag_o  (cap_flag_o),
        .cmp_flag_o  (cmp_flag_o),
        .cmp_rd_data (cmp_rd_data)
    );

    // kinds: 0 count, 1 capture value, 2 capture flag, 3 compare flag, 4 read data
    typedef struct {
        int          due;
        int          kind;
        int          idx;
        logic [15:0] expv;
        string       req;
    } exp_item_t;

    exp_item_t sb_q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference state, from the requirements
    logic [15:0] m_cnt = 16'h0000;
    logic [15:0] m_cap [4] = '{default: 16'h0000};
    logic [3:0]  m_capf = '0;
    logic [15:0] m_cmp [2] = '{default: 16'hFFFF};
    logic [1:0]  m_cmpf = '0;

    // monitor: compares due items shortly after each rising edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        #2;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            automatic exp_item_t it = sb_q.pop_front();
            automatic logic [15:0] act;
            case (it.kind)
                0: act = count_o;
                1: act = cap_val_o[it.idx*16 +: 16];
                2: act = {15'd0, cap_flag_o[it.idx]};
                3: act = {15'd0, cmp_flag_o[it.idx]};
                default: act = cmp_rd_data;
            endcase
            n_chk++;
            if (it.due != cyc || act !== it.expv) begin
                n_fail++;
                $display("FAIL %s kind=%0d ch=%0d cycle=%0d actual=%h expected=%h",
                         it.req, it.kind, it.idx, cyc, act, it.expv);
            end
        end
    end

    task automatic push(input int kind, input int idx, input logic [15:0] v, input string req);
        exp_item_t it;
        it.due = cyc + 1; it.kind = kind; it.idx = idx; it.expv = v; it.req = req;
        sb_q.push_back(it);
    endtask

    // driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(input logic en, input logic [3:0] cp, input logic [3:0] cc,
                        input logic we, input logic ws, input logic [15:0] wd,
                        input logic rs, input logic [1:0] mc, input string req);
        @(negedge clk);
        cnt_en = en; cap_pulse = cp; cap_clr = cc; cmp_wr_en = we;
        cmp_wr_sel = ws; cmp_wr_data = wd; cmp_rd_sel = rs; cmp_clr = mc;
        push(4, 0, m_cmp[int'(rs)], req);
        for (int i = 0; i < 4; i++) begin
            if (cp[i]) begin
                m_cap[i] = m_cnt;
                m_capf[i] = 1'b1;
            end else if (cc[i]) begin
                m_capf[i] = 1'b0;
            end
        end
        for (int j = 0; j < 2; j++) begin
            if (en && m_cnt == m_cmp[j]) m_cmpf[j] = 1'b1;
            else if (mc[j]) m_cmpf[j] = 1'b0;
        end
        if (we) m_cmp[int'(ws)] = wd;
        if (en) m_cnt = m_cnt + 16'd1;
        push(0, 0, m_cnt, req);
        for (int i = 0; i < 4; i++) begin
            push(1, i, m_cap[i], req);
            push(2, i, {15'd0, m_capf[i]}, req);
        end
        for (int j = 0; j < 2; j++) push(3, j, {15'd0, m_cmpf[j]}, req);
    endtask

    task automatic idle(input logic en, input string req);
        step(en, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, req);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9/R8: reset state, both compare registers read 0xFFFF
        step(1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, "R9");
        step(1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b1, 2'b00, "R8");
        idle(1'b0, "R9");
        // R1: enable pulses every third cycle; counter holds in between
        for (int k = 0; k < 3; k++) begin
            idle(1'b1, "R1");
            idle(1'b0, "R1");
            idle(1'b0, "R1");
        end
        // R8: program compare A=5, B=7, then read them back
        step(1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 16'h0005, 1'b0, 2'b00, "R8");
        step(1'b0, 4'h0, 4'h0, 1'b1, 1'b1, 16'h0007, 1'b0, 2'b00, "R8");
        step(1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, "R8");
        step(1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b1, 2'b00, "R8");
        // counter is 3; step to 5 and hold there with no enable
        idle(1'b1, "R1");
        idle(1'b1, "R1");
        // R5: count equals compare A but no enable, flag stays low
        for (int k = 0; k < 4; k++) idle(1'b0, "R5");
        // R5: enable at count 5 sets flag A as counter moves to 6
        idle(1'b1, "R5");
        // R6: at count 6, clear A and hold many cycles, stays clear
        step(1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, "R6");
        for (int k = 0; k < 5; k++) idle(1'b0, "R6");
        // R6: rewrite compare A to current count 6, clear stays effective until enable
        step(1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 16'h0006, 1'b0, 2'b00, "R6");
        for (int k = 0; k < 3; k++) idle(1'b0, "R6");
        // R7: match and clear together on channel A, set wins
        step(1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, "R7");
        // R7: clear A alone, then B matches at 7 with clear on B, set wins
        step(1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b11, "R7");
        step(1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b10, "R7");
        // R2: capture coincident with increment takes pre-increment value
        step(1'b1, 4'h1, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, "R2");
        step(1'b0, 4'h2, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, "R2");
        // R3: two channels together, then one alone
        idle(1'b1, "R3");
        step(1'b0, 4'hC, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, "R3");
        idle(1'b1, "R3");
        step(1'b1, 4'h8, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, "R3");
        // R4: clear flags 0 and 1; capture and clear together on channel 2
        step(1'b0, 4'h4, 4'h7, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, "R4");
        for (int k = 0; k < 3; k++) idle(1'b0, "R4");
        step(1'b0, 4'h0, 4'hF, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, "R4");
        // R1: run continuously across the wrap at 0xFFFF
        while (m_cnt != 16'hFFFD) idle(1'b1, "R1");
        for (int k = 0; k < 5; k++) idle(1'b1, "R1");
        step(1'b0, 4'h1, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, "R2");
        idle(1'b0, "R1");
        idle(1'b0, "R1");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule